// File: doc/BRIEF.md
# Recirculating Serial-I/O Shift Register

This block is a 16-bit shift register that talks to the outside world through one shared serial data line plus a 16-bit parallel load bus. The shared line is split here into a serial input, a serial output and an output enable, which the pad ring combines into a single bidirectional pin. All state changes happen on the falling edge of the clock.

An active-low select, a direction control and a mode control choose one of four operations:

- **Hold.** Nothing changes and the output is released.
- **Serial fill.** Data is shifted in from the shared line.
- **Rotating read-out.** The top bit is presented on the line and also fed back into the bottom bit, so sixteen clocks give the original contents back.
- **Parallel capture.** The whole word is loaded from the bus.

A typical use is to capture a word in parallel, then stream it out in sixteen rotating clocks. The register is left unchanged afterwards. A word can also be written bit by bit from the line.

An asynchronous active-low reset clears the register. The reset is released synchronously through a short synchronizer clocked on the same falling edge.

Top module: `sio_rotreg`

## Requirements
- R1: The register changes only on a falling clock edge: the serial output keeps its value across a rising edge and takes a new value after the following falling edge.
- R2: While `cs_n` is high, falling edges leave the 16-bit contents unchanged whatever the other controls and data inputs do, and `ser_oe` is 0.
- R3: With `cs_n`=0 and `rw`=0 (serial fill), each falling edge moves every bit one place towards bit 15 and loads `ser_in` into bit 0, so the first of 16 bits shifted in ends in bit 15. `mode` has no effect in this operation.
- R4: With `cs_n`=0, `rw`=1 and `mode`=0 (rotating read-out), each falling edge moves every bit one place towards bit 15 and copies the old bit 15 into bit 0. After 16 such edges the contents equal those before the first edge.
- R5: With `cs_n`=0, `rw`=1 and `mode`=1 (parallel capture), a falling edge loads `par_d[i]` into bit i for every i, with no shifting. Repeated edges with the same `par_d` leave the contents unchanged.
- R6: `ser_out` always equals bit 15 of the register. `ser_oe` is 1 exactly when `cs_n`=0 and `rw`=1, and follows those inputs without waiting for a clock edge.
- R7: While `rst_n` is low, the register reads all zeros. After `rst_n` rises, the first two falling edges leave the register unchanged, and the third falling edge is the first that can update it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the register updates on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; when high, the register holds and the output is released |
| rw | input | 1 | 1 = drive the shared line, 0 = receive from it |
| mode | input | 1 | When `rw`=1: 1 = parallel capture, 0 = rotating read-out |
| par_d | input | 16 | Parallel data word; bit i loads register bit i |
| ser_in | input | 1 | Serial data arriving from the shared line |
| ser_out | output | 1 | Serial data for the shared line (register bit 15) |
| ser_oe | output | 1 | Output enable for the shared line driver |

## Verification
The bench builds the block with its default parameters: a 16-bit register and a two-stage reset synchronizer. With these values, a full rotation takes only sixteen clocks, so every stored word can be read back through the serial output and then found unchanged on a second pass. The two-stage synchronizer puts the first effective edge after reset at a fixed, countable position, so the bench can check the reset release edge by edge.

// File: rtl/sio_rotreg_pkg.sv
package sio_rotreg_pkg;

  typedef enum logic [1:0] {
    OP_HOLD     = 2'd0,
    OP_SHIFT_IN = 2'd1,
    OP_ROTATE   = 2'd2,
    OP_LOAD     = 2'd3
  } op_t;

endpackage

// File: rtl/sio_rst_sync.sv
module sio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/sio_ctrl.sv
module sio_ctrl
  import sio_rotreg_pkg::*;
(
  input  logic cs_n,
  input  logic rw,
  input  logic mode,
  output op_t  op,
  output logic drive_en
);

  always_comb begin
    if (cs_n)     op = OP_HOLD;
    else if (!rw) op = OP_SHIFT_IN;
    else if (mode) op = OP_LOAD;
    else          op = OP_ROTATE;
  end

  assign drive_en = !cs_n && rw;

endmodule

// File: rtl/sio_shift_core.sv
module sio_shift_core
  import sio_rotreg_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  op_t              op,
  input  logic [WIDTH-1:0] par_d,
  input  logic             ser_in,
  output logic             top_bit
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] q_next;
  logic             q_en;

  always_comb begin
    q_en   = 1'b1;
    q_next = q;
    unique case (op)
      OP_HOLD:     q_en   = 1'b0;
      OP_SHIFT_IN: q_next = {q[MSB-1:0], ser_in};
      OP_ROTATE:   q_next = {q[MSB-1:0], q[MSB]};
      OP_LOAD:     q_next = par_d;
      default:     q_en   = 1'b0;
    endcase
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_next;
  end

  assign top_bit = q[MSB];

  // R2
  a_r2_hold_stable: assert property (@(negedge clk) disable iff (!rst_n)
    (op == OP_HOLD) |=> $stable(q));

  // R3
  a_r3_fill_order: assert property (@(negedge clk) disable iff (!rst_n)
    (op == OP_SHIFT_IN) |=> (q[0] == $past(ser_in)) && (q[MSB:1] == $past(q[MSB-1:0])));

  // R4
  a_r4_wraps_top: assert property (@(negedge clk) disable iff (!rst_n)
    (op == OP_ROTATE) |=> (q[0] == $past(q[MSB])) && (q[MSB:1] == $past(q[MSB-1:0])));

  // R5
  a_r5_word_capture: assert property (@(negedge clk) disable iff (!rst_n)
    (op == OP_LOAD) |=> (q == $past(par_d)));

endmodule

// File: rtl/sio_rotreg.sv
module sio_rotreg
  import sio_rotreg_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rw,
  input  logic             mode,
  input  logic [WIDTH-1:0] par_d,
  input  logic             ser_in,
  output logic             ser_out,
  output logic             ser_oe
);

  logic rst_core_n;
  op_t  op;
  logic drive_en;
  logic top_bit;

  sio_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  sio_ctrl u_ctrl (
    .cs_n     (cs_n),
    .rw       (rw),
    .mode     (mode),
    .op       (op),
    .drive_en (drive_en)
  );

  sio_shift_core #(.WIDTH(WIDTH)) u_core (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .op      (op),
    .par_d   (par_d),
    .ser_in  (ser_in),
    .top_bit (top_bit)
  );

  assign ser_out = top_bit;
  assign ser_oe  = drive_en;

  // R6
  a_r6_released_when_deselected: assert property (@(negedge clk) disable iff (!rst_n)
    cs_n |-> !ser_oe);

  // R6
  a_r6_released_when_receiving: assert property (@(negedge clk) disable iff (!rst_n)
    !rw |-> !ser_oe);

  // R7
  a_r7_zero_in_reset: assert property (@(negedge clk)
    !rst_core_n |-> !ser_out);

endmodule

// File: tb/sim_sio_rotreg.sv
module sim_sio_rotreg;

  logic        clk;
  logic        rst_n;
  logic        cs_n;
  logic        rw;
  logic        mode;
  logic [15:0] par_d;
  logic        ser_in;
  logic        ser_out;
  logic        ser_oe;

  int n_checks;
  int n_fail;

  sio_rotreg u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .rw      (rw),
    .mode    (mode),
    .par_d   (par_d),
    .ser_in  (ser_in),
    .ser_out (ser_out),
    .ser_oe  (ser_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Wait for a falling edge, then settle away from both edges.
  task automatic tick();
    @(negedge clk);
    #2;
  endtask

  task automatic set_ctl(input logic c, input logic r, input logic m);
    cs_n = c;
    rw   = r;
    mode = m;
  endtask

  // Stream all bits out through rotation; contents end unchanged.
  task automatic read_word(output logic [15:0] w);
    set_ctl(1'b0, 1'b1, 1'b0);
    for (int i = 15; i >= 0; i--) begin
      w[i] = ser_out;
      tick();
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    set_ctl(1'b0, 1'b1, 1'b1);
    par_d  = 16'hFFFF;
    ser_in = 1'b1;
    tick();
    tick();
    check("R7 zero in reset", {15'd0, ser_out}, 16'd0);
    check("R6 oe in reset", {15'd0, ser_oe}, 16'd1);
    rst_n = 1'b1;
    tick();
    check("R7 first edge after release", {15'd0, ser_out}, 16'd0);
    tick();
    check("R7 second edge after release", {15'd0, ser_out}, 16'd0);
    tick();
    check("R7 third edge updates", {15'd0, ser_out}, 16'd1);
  endtask

  task automatic t_oe();
    set_ctl(1'b1, 1'b1, 1'b0); #1;
    check("R6 oe cs_n=1 rw=1", {15'd0, ser_oe}, 16'd0);
    set_ctl(1'b0, 1'b0, 1'b1); #1;
    check("R6 oe cs_n=0 rw=0", {15'd0, ser_oe}, 16'd0);
    set_ctl(1'b0, 1'b1, 1'b0); #1;
    check("R6 oe cs_n=0 rw=1", {15'd0, ser_oe}, 16'd1);
    set_ctl(1'b1, 1'b0, 1'b0); #1;
    check("R6 oe cs_n=1 rw=0", {15'd0, ser_oe}, 16'd0);
  endtask

  task automatic t_edge();
    logic [15:0] w;
    set_ctl(1'b0, 1'b1, 1'b1);
    par_d = 16'h0000;
    tick();
    par_d = 16'h8000;
    @(posedge clk);
    #1;
    check("R1 no change on rising edge", {15'd0, ser_out}, 16'd0);
    tick();
    check("R1 change after falling edge", {15'd0, ser_out}, 16'd1);
    read_word(w);
    check("R5 capture 8000", w, 16'h8000);
  endtask

  task automatic t_pload_rotate(input logic [15:0] v);
    logic [15:0] w;
    set_ctl(1'b0, 1'b1, 1'b1);
    par_d = v;
    tick();
    tick();
    tick();
    check("R5 repeated capture, R6 ser_out is bit 15", {15'd0, ser_out}, {15'd0, v[15]});
    read_word(w);
    check("R5 captured word", w, v);
    read_word(w);
    check("R4 16 rotations restore", w, v);
    set_ctl(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) tick();
    check("R4 partial rotation", {15'd0, ser_out}, {15'd0, v[11]});
    for (int i = 0; i < 12; i++) tick();
    read_word(w);
    check("R4 back after 4+12", w, v);
  endtask

  task automatic t_serial_fill(input logic [15:0] v);
    logic [15:0] w;
    par_d = ~v;
    for (int i = 15; i >= 0; i--) begin
      set_ctl(1'b0, 1'b0, i[0]);
      ser_in = v[i];
      tick();
      if (i == 8) check("R6 oe off in fill", {15'd0, ser_oe}, 16'd0);
    end
    read_word(w);
    check("R3 fill order, mode ignored", w, v);
  endtask

  task automatic t_hold();
    logic [15:0] w;
    set_ctl(1'b0, 1'b1, 1'b1);
    par_d = 16'h3C5A;
    tick();
    par_d  = 16'hFFFF;
    ser_in = 1'b1;
    for (int i = 0; i < 5; i++) begin
      set_ctl(1'b1, i[0], i[1]);
      tick();
    end
    check("R2 oe off while deselected", {15'd0, ser_oe}, 16'd0);
    read_word(w);
    check("R2 contents held", w, 16'h3C5A);
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    rst_n  = 1'b0;
    cs_n   = 1'b1;
    rw     = 1'b0;
    mode   = 1'b0;
    par_d  = '0;
    ser_in = 1'b0;
    t_reset();
    t_oe();
    t_edge();
    t_pload_rotate(16'hA5C3);
    t_pload_rotate(16'h0001);
    t_serial_fill(16'hB29E);
    t_serial_fill(16'h8001);
    t_hold();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule